// File: doc/BRIEF.md
# Fast Reciprocal Square Root Unit

This block approximates 1/sqrt(x) for a single-precision floating-point operand. It needs no lookup table. A first guess comes from integer arithmetic on the raw bit pattern: the operand bits are halved as an unsigned integer and subtracted from the constant 0x5F3759DF. That guess is then sharpened by exactly one Newton-Raphson step, y' = y * (1.5 - 0.5 * x * y * y). The multiplies in this step are single-precision with round-to-nearest-even. The constant term is formed by an internal fixed-point subtract.

A two-bit mode selects what the final stage returns. Code 0 returns the refined reciprocal square root. Code 1 returns the square root, formed as x times that value. Code 2 returns the reciprocal, formed as the square of that value. Code 3 behaves like code 0.

The unit is fully pipelined. It accepts one operand per clock and returns each result a fixed six cycles later. Accuracy is approximate by design. Denormal operands are flushed to zero. Operands outside the function's domain follow a fixed policy and yield a quiet NaN or a fixed constant.

Top module: `frsqrt_unit`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle of `out_valid` exactly 6 clock edges later, with inputs accepted back-to-back and results returned in order; `out_valid` is never high without such an input.
- R2: For a positive normal operand the result equals, within a relative error of 2e-6, the value obtained by taking seed bits 0x5F3759DF minus (operand bits shifted right by one), reading them as a float y, forming y*(1.5-0.5*x*y*y) once, and then applying the mode's final step.
- R3: Mode code 0 (and reserved code 3) returns 1/sqrt(x) with relative error below 0.2% for positive normal operands.
- R4: Mode code 1 returns sqrt(x), computed as x times the refined estimate, with relative error below 0.2%.
- R5: Mode code 2 returns 1/x, computed as the square of the refined estimate, with relative error below 0.4% for operands whose reciprocal is normal.
- R6: An operand whose exponent field (bits 30:23) is zero, whether it is zero or denormal, produces the quiet NaN 0x7FC00000 in every mode.
- R7: Any operand with sign bit 31 set, including -0 and -infinity, produces 0x7FC00000 in every mode.
- R8: A NaN operand (exponent field all ones, fraction nonzero) produces 0x7FC00000 in every mode.
- R9: Positive infinity (0x7F800000) produces 0x00000000 in modes 0, 2 and 3, and 0x7F800000 in mode 1.
- R10: Every valid result has sign bit 31 clear.
- R11: While and after reset, `out_valid` is low until a new operand has travelled the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| in_mode | input | 2 | 0 rsqrt, 1 sqrt, 2 reciprocal, 3 as 0 |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Single-precision result |

## Verification
A corrupted seed, correction term or multiplier shows up on the very result that passes through it, six cycles after that operand was applied. It appears as a relative error well above the 2e-6 model bound, so a single operand exposes it. A broken lane register would misalign a result's mode or classification with its data. Mixed modes sent back-to-back make this visible as a wrong value or a wrong special code on the neighbouring result. A valid bit lost or duplicated in the pipe changes the time at which results emerge, and the scoreboard compares each result's arrival cycle against the cycle its operand entered plus six.

// File: rtl/frsqrt_pkg.sv
package frsqrt_pkg;

    localparam int          LAT      = 6;
    localparam logic [31:0] MAGIC    = 32'h5F3759DF;
    localparam logic [31:0] QNAN     = 32'h7FC00000;
    localparam logic [31:0] PINF     = 32'h7F800000;
    localparam int          FIXW     = 34;
    localparam logic [FIXW-1:0] THREE_Q = 34'h0_C000_0000; // 3.0 with 30 fraction bits

    typedef enum logic [1:0] {
        MODE_RSQRT = 2'd0,
        MODE_SQRT  = 2'd1,
        MODE_RECIP = 2'd2,
        MODE_RSV   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        KIND_CALC = 2'd0,
        KIND_NAN  = 2'd1,
        KIND_ZERO = 2'd2,
        KIND_INF  = 2'd3
    } kind_e;

    typedef struct packed {
        logic        vld;
        mode_e       mode;
        kind_e       kind;
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] acc;
    } lane_t;

    // Single-precision multiply, normal operands, round to nearest even,
    // underflow flushed to zero, overflow to infinity.
    function automatic logic [31:0] fp_mul(input logic [31:0] a, input logic [31:0] b);
        logic [47:0]        prod;
        logic [23:0]        man;
        logic [24:0]        sum;
        logic               rnd, stk, up, sgn;
        logic signed [10:0] ex;
        sgn  = a[31] ^ b[31];
        prod = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
        ex   = $signed({3'b0, a[30:23]}) + $signed({3'b0, b[30:23]}) - 11'sd127;
        if (prod[47]) begin
            man = prod[47:24];
            rnd = prod[23];
            stk = |prod[22:0];
            ex  = ex + 11'sd1;
        end else begin
            man = prod[46:23];
            rnd = prod[22];
            stk = |prod[21:0];
        end
        up  = rnd & (stk | man[0]);
        sum = {1'b0, man} + {24'b0, up};
        if (sum[24]) begin
            man = sum[24:1];
            ex  = ex + 11'sd1;
        end else begin
            man = sum[23:0];
        end
        if (a[30:23] == 8'd0 || b[30:23] == 8'd0 || ex <= 11'sd0)
            return {sgn, 31'b0};
        else if (ex >= 11'sd255)
            return {sgn, 8'hFF, 23'b0};
        else
            return {sgn, ex[7:0], man[22:0]};
    endfunction

    // Correction factor 1.5 - 0.5*t = (3 - t)/2, formed in fixed point.
    function automatic logic [31:0] nr_corr(input logic [31:0] t);
        logic [FIXW-1:0] fx, diff, norm;
        logic [5:0]      lead;
        logic [7:0]      e, e_out;
        e = t[30:23];
        if (e < 8'd120)      fx = '0;
        else if (e > 8'd128) fx = THREE_Q;
        else                 fx = {10'b0, 1'b1, t[22:0]} << (e - 8'd120);
        diff = (fx >= THREE_Q) ? FIXW'(1) : (THREE_Q - fx);
        lead = '0;
        for (int i = 0; i < FIXW; i++)
            if (diff[i]) lead = 6'(i);
        norm  = diff << (6'd33 - lead);
        e_out = 8'd96 + {2'b0, lead};
        return {1'b0, e_out, norm[32:10]};
    endfunction

endpackage

// File: rtl/frsqrt_classify.sv
module frsqrt_classify
    import frsqrt_pkg::*;
(
    input  logic [31:0] x,
    input  mode_e       mode,
    output kind_e       kind,
    output logic [31:0] seed
);
    logic       is_nan, is_inf, is_low;

    assign is_nan = (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    assign is_inf = (x[30:23] == 8'hFF) && (x[22:0] == 23'd0);
    assign is_low = (x[30:23] == 8'd0);

    always_comb begin
        if (is_nan || x[31] || is_low)
            kind = KIND_NAN;
        else if (is_inf)
            kind = (mode == MODE_SQRT) ? KIND_INF : KIND_ZERO;
        else
            kind = KIND_CALC;
    end

    assign seed = MAGIC - {1'b0, x[31:1]};
endmodule

// File: rtl/frsqrt_fmul.sv
module frsqrt_fmul
    import frsqrt_pkg::*;
(
    input  logic [31:0] a,
    input  logic [31:0] b,
    output logic [31:0] p
);
    assign p = fp_mul(a, b);
endmodule

// File: rtl/frsqrt_corr.sv
module frsqrt_corr
    import frsqrt_pkg::*;
(
    input  logic [31:0] t,
    output logic [31:0] c
);
    assign c = nr_corr(t);
endmodule

// File: rtl/frsqrt_unit.sv
module frsqrt_unit
    import frsqrt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic [1:0]  in_mode,
    output logic        out_valid,
    output logic [31:0] out_data
);
    lane_t       s1, s2, s3, s4, s5;
    kind_e       kind_in;
    logic [31:0] seed, m2, m3, c4, m5, m6, fin_a, result;

    frsqrt_classify u_cls (.x(in_data), .mode(mode_e'(in_mode)), .kind(kind_in), .seed(seed));

    // x*y, then (x*y)*y, then correction, then refined y, then mode step
    frsqrt_fmul u_mxy  (.a(s1.x),   .b(s1.y),   .p(m2));
    frsqrt_fmul u_mxyy (.a(s2.acc), .b(s2.y),   .p(m3));
    frsqrt_corr u_corr (.t(s3.acc), .c(c4));
    frsqrt_fmul u_mref (.a(s4.y),   .b(s4.acc), .p(m5));

    assign fin_a = (s5.mode == MODE_SQRT) ? s5.x : s5.y;
    frsqrt_fmul u_mfin (.a(fin_a),  .b(s5.y),   .p(m6));

    always_comb begin
        unique case (s5.kind)
            KIND_NAN:  result = QNAN;
            KIND_ZERO: result = 32'd0;
            KIND_INF:  result = PINF;
            default:   result = (s5.mode == MODE_SQRT || s5.mode == MODE_RECIP) ? m6 : s5.y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= '0;
            s2        <= '0;
            s3        <= '0;
            s4        <= '0;
            s5        <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            s1        <= '{vld: in_valid, mode: mode_e'(in_mode), kind: kind_in,
                          x: in_data, y: seed, acc: 32'd0};
            s2        <= s1;
            s2.acc    <= m2;
            s3        <= s2;
            s3.acc    <= m3;
            s4        <= s3;
            s4.acc    <= c4;
            s5        <= s4;
            s5.y      <= m5;
            out_valid <= s5.vld;
            out_data  <= result;
        end
    end
endmodule

// File: rtl/frsqrt_checker.sv
module frsqrt_checker
    import frsqrt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic [31:0] out_data
);
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##LAT out_valid);

    p_no_orphan_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, LAT));

    p_neg_nan_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[31]) |-> ##LAT (out_data == QNAN));

    p_nan_in_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0)
            |-> ##LAT (out_data == QNAN));

    p_zero_in_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[30:23] == 8'd0) |-> ##LAT (out_data == QNAN));

    p_sign_clear_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_data[31]);
endmodule

bind frsqrt_unit frsqrt_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_frsqrt_unit.sv
module tb_frsqrt_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_data;

    frsqrt_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_mode(in_mode), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] x;
        logic [1:0]  mode;
        int          due;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real b2r(input logic [31:0] b);
        real v;
        if (b[30:23] == 8'd0) return 0.0;
        v = (1.0 + real'(b[22:0]) / 8388608.0) * $pow(2.0, real'(int'(b[30:23]) - 127));
        return b[31] ? -v : v;
    endfunction

    task automatic check(input string tag, input bit ok, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic check_rel(input string tag, input real act, input real exp, input real tol);
        real rel;
        rel = (act - exp) / exp;
        if (rel < 0.0) rel = -rel;
        check(tag, rel < tol, $sformatf("%g", act), $sformatf("%g (tol %g)", exp, tol));
    endtask

    // Expected handling of out-of-domain operands (R6..R9)
    function automatic bit special_exp(input logic [31:0] x, input logic [1:0] m,
                                       output logic [31:0] v, output string tag);
        if (x[31]) begin v = 32'h7FC00000; tag = "R7"; return 1; end
        if (x[30:23] == 8'hFF && x[22:0] != 0) begin v = 32'h7FC00000; tag = "R8"; return 1; end
        if (x[30:23] == 8'd0) begin v = 32'h7FC00000; tag = "R6"; return 1; end
        if (x[30:23] == 8'hFF) begin
            v = (m == 2'd1) ? 32'h7F800000 : 32'h0; tag = "R9"; return 1;
        end
        v = 0; tag = ""; return 0;
    endfunction

    task automatic send(input logic [31:0] x, input logic [1:0] m);
        item_t it;
        in_valid = 1'b1;
        in_data  = x;
        in_mode  = m;
        it.x = x; it.mode = m; it.due = cyc + LATENCY;
        q.push_back(it);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    function automatic logic [31:0] rnd_norm();
        logic [7:0] e;
        e = 8'(2 + $urandom_range(248));
        return {1'b0, e, 23'($urandom)};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check("R1", 0, "unexpected out_valid", "no result");
            end else begin
                item_t it;
                logic [31:0] sv;
                string tg;
                real x, y, yr, mdl, act, truth;
                it = q.pop_front();
                check("R1", it.due == cyc, $sformatf("cycle %0d", cyc), $sformatf("cycle %0d", it.due));
                if (special_exp(it.x, it.mode, sv, tg)) begin
                    check(tg, out_data == sv, $sformatf("%h", out_data), $sformatf("%h", sv));
                end else begin
                    x   = b2r(it.x);
                    y   = b2r(32'h5F3759DF - (it.x >> 1));
                    yr  = y * (1.5 - 0.5 * x * y * y);
                    act = b2r(out_data);
                    check("R10", out_data[31] == 1'b0, $sformatf("%h", out_data), "sign 0");
                    case (it.mode)
                        2'd1: begin mdl = x * yr;   truth = $sqrt(x);
                                    check_rel("R4", act, truth, 2.0e-3); end
                        2'd2: begin mdl = yr * yr;  truth = 1.0 / x;
                                    check_rel("R5", act, truth, 4.0e-3); end
                        default: begin mdl = yr;    truth = 1.0 / $sqrt(x);
                                    check_rel("R3", act, truth, 2.0e-3); end
                    endcase
                    check_rel("R2", act, mdl, 2.0e-6);
                end
            end
        end
        if (!rst && q.size() != 0 && q[0].due < cyc)
            check("R1", 0, "missing out_valid", $sformatf("result due cycle %0d", q[0].due));
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("R1", 0, "watchdog expired", "run to finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset holds the result strobe low
        check("R11", out_valid == 1'b0, $sformatf("%b", out_valid), "0");
        rst = 1'b0;
        idle(8);
        check("R11", out_valid == 1'b0, $sformatf("%b", out_valid), "0 with no input");

        // directed normal values in every mode (R2..R5)
        for (int m = 0; m < 4; m++) send(32'h3F800000, 2'(m));  // 1.0
        for (int m = 0; m < 4; m++) send(32'h40800000, 2'(m));  // 4.0
        send(32'h00800000, 2'd1);                               // smallest normal
        send(32'h7E000000, 2'd0);                               // large
        idle(8);

        // out-of-domain operands, back-to-back, every mode (R6..R9)
        for (int m = 0; m < 4; m++) begin
            send(32'h00000000, 2'(m));   // +0, R6
            send(32'h00012345, 2'(m));   // denormal, R6
            send(32'h80000000, 2'(m));   // -0, R7
            send(32'hBF800000, 2'(m));   // -1.0, R7
            send(32'hFF800000, 2'(m));   // -inf, R7
            send(32'h7FC00000, 2'(m));   // qNaN, R8
            send(32'h7F800001, 2'(m));   // sNaN, R8
            send(32'h7F800000, 2'(m));   // +inf, R9
        end
        idle(8);

        // back-to-back random operands, mixed modes and specials interleaved
        for (int i = 0; i < 400; i++) begin
            if (i % 37 == 5) send(32'hC0400000, 2'($urandom_range(3)));
            else             send(rnd_norm(), 2'($urandom_range(3)));
        end
        // random operands with bubbles
        for (int i = 0; i < 300; i++) begin
            send(rnd_norm(), 2'($urandom_range(3)));
            if ($urandom_range(2) == 0) idle(1 + $urandom_range(3));
        end
        idle(12);
        check("R1", q.size() == 0, $sformatf("%0d pending", q.size()), "0 pending");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule